// File: doc/BRIEF.md
# Vector Pack/Unpack Index Sequencer

This block produces the element offsets for a vector register move in which every vector element is a short subvector of one to four lanes. Once started, it emits one pair of offsets for each element lane moved: a source offset, which says where to read, and a destination offset, which says where to write. The two offset generators always advance together, so the n-th source offset goes with the n-th destination offset.

Each side can use one of two layouts. In the interleaved layout the lanes of a subvector sit next to each other, so the offset of lane j of element i is `i*S + j`. In the planar layout each lane has its own block of VL entries, so the offset is `i + VL*j`. Pairs are always counted with the element index i outer and the lane index j inner. A planar source with an interleaved destination packs separate lane arrays into subvectors. The reverse choice unpacks them. Setting both sides planar, or neither, gives a straight copy order.

The consumer takes pairs through a valid/ready handshake. The sequencer signals the end of a run with a one-cycle completion pulse.

Top module: `vec_reorder_seq`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `seq_done` are low until a sequence is started.
- R2: `sub_code` k (2 bits) selects a subvector of k+1 lanes. A started run delivers exactly `vec_len*(k+1)` accepted pairs. `seq_done` is high for exactly one cycle, in the cycle after the last accepted pair, and `out_valid` is low in that cycle.
- R3: With the interleaved layout, the offset of pair n is n, where n = i*S + j for element i and lane j.
- R4: With the planar layout, the offset of pair n is i + VL*j, with i = n / S and j = n % S.
- R5: `mode_word` bit 14 selects the planar layout for the source and bit 15 selects it for the destination. All other bits of `mode_word` have no effect.
- R6: With bits 14 and 15 both set, both sides use the planar layout.
- R7: While `out_valid` is high and `out_ready` is low, the pair is held stable and the run does not advance.
- R8: A start received while a run is in progress is ignored, together with the length and mode values presented with it.
- R9: A start with `vec_len` equal to 0 or above MAX_VL (64 by default) is ignored: no pair and no `seq_done` follow.
- R10: The first pair of every run is (0, 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run using the length, subvector and mode inputs |
| vec_len | input | 7 | Vector length, 1 to MAX_VL |
| sub_code | input | 2 | Subvector lanes minus one |
| mode_word | input | 16 | Mode field; bit 14 selects a planar source, bit 15 a planar destination |
| out_ready | input | 1 | Consumer accepts the current pair |
| src_ofs | output | 8 | Source element offset |
| dst_ofs | output | 8 | Destination element offset |
| out_valid | output | 1 | Pair is valid |
| seq_done | output | 1 | One-cycle pulse after the last accepted pair |

## Verification
Runs use all four layout combinations (copy, pack, unpack, both planar) with subvector sizes of one, three and four lanes. The vector length ranges from 1 to the maximum. This separates the two offset formulas from each other, and from the degenerate case where they coincide because the subvector has a single lane. A mode word with every bit except 14 and 15 set shows that no other bit steers the layout. Irregular ready patterns, together with a start strobe and new configuration values injected mid-run, separate a correct stall and config latch from one that skips or corrupts pairs. Starts with a length of zero or above the maximum confirm that no run begins.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
   localparam int MAX_SUB = 4;
   localparam int SUB_W   = 2;

   typedef enum logic {
      ORD_INTERLEAVED = 1'b0,
      ORD_PLANAR      = 1'b1
   } order_e;

   function automatic order_e order_of(input logic planar_bit);
      return planar_bit ? ORD_PLANAR : ORD_INTERLEAVED;
   endfunction
endpackage

// File: rtl/vrs_ctrl.sv
module vrs_ctrl
   import vrs_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int VL_W   = 7,
   parameter int CNT_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VL_W-1:0]  vec_len,
   input  logic [SUB_W-1:0] sub_code,
   input  logic             pack_in,
   input  logic             unpack_in,
   input  logic             out_ready,
   output logic             load,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [VL_W-1:0]  vl_q,
   output logic [SUB_W-1:0] sub_q,
   output order_e           src_ord,
   output order_e           dst_ord
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] total;
   logic             len_ok;
   logic             at_last;

   always_comb begin
      len_ok  = (vec_len != '0) && (int'(vec_len) <= MAX_VL);
      total   = CNT_W'(vec_len) * (CNT_W'(sub_code) + CNT_W'(1));
      load    = start && !busy && len_ok;
      step    = busy && out_ready;
      at_last = (cnt_q == last_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt_q   <= '0;
         last_q  <= '0;
         vl_q    <= '0;
         sub_q   <= '0;
         src_ord <= ORD_INTERLEAVED;
         dst_ord <= ORD_INTERLEAVED;
      end else begin
         done <= step && at_last;
         if (load) begin
            busy    <= 1'b1;
            cnt_q   <= '0;
            last_q  <= total - CNT_W'(1);
            vl_q    <= vec_len;
            sub_q   <= sub_code;
            src_ord <= order_of(pack_in);
            dst_ord <= order_of(unpack_in);
         end else if (step) begin
            if (at_last) busy <= 1'b0;
            else         cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/vrs_ofs_gen.sv
module vrs_ofs_gen
   import vrs_pkg::*;
#(
   parameter int VL_W  = 7,
   parameter int OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  order_e           ord,
   input  logic [VL_W-1:0]  vl_q,
   input  logic [SUB_W-1:0] sub_q,
   output logic [OFS_W-1:0] ofs
);
   logic [SUB_W-1:0] lane_q;
   logic [OFS_W-1:0] elem_q;
   logic [OFS_W-1:0] ofs_q;

   assign ofs = ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         elem_q <= '0;
         ofs_q  <= '0;
      end else if (load) begin
         lane_q <= '0;
         elem_q <= '0;
         ofs_q  <= '0;
      end else if (step) begin
         if (lane_q == sub_q) begin
            lane_q <= '0;
            elem_q <= elem_q + OFS_W'(1);
         end else begin
            lane_q <= lane_q + SUB_W'(1);
         end
         if (ord == ORD_PLANAR) begin
            if (lane_q == sub_q) ofs_q <= elem_q + OFS_W'(1);
            else                 ofs_q <= ofs_q + OFS_W'(vl_q);
         end else begin
            ofs_q <= ofs_q + OFS_W'(1);
         end
      end
   end
endmodule

// File: rtl/vec_reorder_seq.sv
module vec_reorder_seq
   import vrs_pkg::*;
#(
   parameter int MAX_VL     = 64,
   parameter int VL_W       = $clog2(MAX_VL + 1),
   parameter int OFS_W      = 8,
   parameter int MODE_W     = 16,
   parameter int PACK_BIT   = 14,
   parameter int UNPACK_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VL_W-1:0]   vec_len,
   input  logic [SUB_W-1:0]  sub_code,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              out_ready,
   output logic [OFS_W-1:0]  src_ofs,
   output logic [OFS_W-1:0]  dst_ofs,
   output logic              out_valid,
   output logic              seq_done
);
   localparam int MAX_PAIRS = MAX_VL * MAX_SUB;
   localparam int CNT_W     = $clog2(MAX_PAIRS + 1);

   if (OFS_W < $clog2(MAX_PAIRS)) begin : g_bad_ofs
      $error("OFS_W too narrow for MAX_VL*MAX_SUB offsets");
   end
   if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vl
      $error("VL_W too narrow for MAX_VL");
   end
   if (PACK_BIT >= MODE_W || UNPACK_BIT >= MODE_W || PACK_BIT == UNPACK_BIT) begin : g_bad_mode
      $error("mode bit positions out of range");
   end

   logic             load, step, busy, done;
   logic [VL_W-1:0]  vl_q;
   logic [SUB_W-1:0] sub_q;
   order_e           side_ord [2];
   logic [OFS_W-1:0] side_ofs [2];

   vrs_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .vec_len   (vec_len),
      .sub_code  (sub_code),
      .pack_in   (mode_word[PACK_BIT]),
      .unpack_in (mode_word[UNPACK_BIT]),
      .out_ready (out_ready),
      .load      (load),
      .step      (step),
      .busy      (busy),
      .done      (done),
      .vl_q      (vl_q),
      .sub_q     (sub_q),
      .src_ord   (side_ord[0]),
      .dst_ord   (side_ord[1])
   );

   for (genvar s = 0; s < 2; s++) begin : g_side
      vrs_ofs_gen #(.VL_W(VL_W), .OFS_W(OFS_W)) u_gen (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .step  (step),
         .ord   (side_ord[s]),
         .vl_q  (vl_q),
         .sub_q (sub_q),
         .ofs   (side_ofs[s])
      );
   end

   assign src_ofs   = side_ofs[0];
   assign dst_ofs   = side_ofs[1];
   assign out_valid = busy;
   assign seq_done  = done;
endmodule

// File: rtl/vrs_chk.sv
module vrs_chk #(
   parameter int OFS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_ready,
   input logic             out_valid,
   input logic             seq_done,
   input logic [OFS_W-1:0] src_ofs,
   input logic [OFS_W-1:0] dst_ofs
);
   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(src_ofs) && $stable(dst_ofs));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   assert_done_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !out_valid && $past(out_valid && out_ready));

   assert_first_pair_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> src_ofs == '0 && dst_ofs == '0);
endmodule

bind vec_reorder_seq vrs_chk #(.OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_ready (out_ready),
   .out_valid (out_valid),
   .seq_done  (seq_done),
   .src_ofs   (src_ofs),
   .dst_ofs   (dst_ofs)
);

// File: tb/vec_reorder_seq_test.sv
module vec_reorder_seq_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] vec_len = '0;
   logic [1:0] sub_code = '0;
   logic [15:0] mode_word = '0;
   logic       out_ready = 1'b1;
   logic [7:0] src_ofs, dst_ofs;
   logic       out_valid, seq_done;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_reorder_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
      .sub_code(sub_code), .mode_word(mode_word), .out_ready(out_ready),
      .src_ofs(src_ofs), .dst_ofs(dst_ofs), .out_valid(out_valid), .seq_done(seq_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ofs(int n, int vl, int s, bit planar);
      return planar ? (n / s) + vl * (n % s) : n;
   endfunction

   // R3 R4 R5 R6 R2 R7 R8 R10: one complete run with a chosen ready pattern
   task automatic run_seq(input int vl, input int sc, input logic [15:0] mode,
                          input bit stall, input bit inject);
      int  s = sc + 1;
      int  total = vl * s;
      int  n = 0;
      int  guard = 0;
      bit  held = 0;
      bit  pk = mode[14];
      bit  up = mode[15];
      int  prev_src = 0, prev_dst = 0;
      @(negedge clk);
      vec_len = 7'(vl); sub_code = 2'(sc); mode_word = mode; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n < total && guard < 4000) begin
         chk("R2 valid during run", int'(out_valid), 1);
         if (held) begin
            chk("R7 src held", int'(src_ofs), prev_src);
            chk("R7 dst held", int'(dst_ofs), prev_dst);
         end
         if (n == 0) begin
            chk("R10 first src", int'(src_ofs), 0);
            chk("R10 first dst", int'(dst_ofs), 0);
         end
         chk(pk ? "R4 src planar" : "R3 src interleaved", int'(src_ofs), exp_ofs(n, vl, s, pk));
         chk(up ? "R4 dst planar" : "R3 dst interleaved", int'(dst_ofs), exp_ofs(n, vl, s, up));
         chk("R2 no early done", int'(seq_done), 0);
         prev_src = int'(src_ofs); prev_dst = int'(dst_ofs);
         // R8: new start with different settings mid-run
         if (inject && guard == 2) begin
            start = 1'b1; vec_len = 7'd3; sub_code = 2'd0; mode_word = ~mode;
         end else begin
            start = 1'b0;
         end
         out_ready = stall ? ((guard % 3) != 1) : 1'b1;
         held = !out_ready;
         if (out_ready) n++;
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      chk("R2 pair count", n, total);
      chk("R2 done pulse", int'(seq_done), 1);
      chk("R2 valid low at done", int'(out_valid), 0);
      out_ready = 1'b1;
      @(negedge clk);
      chk("R2 done one cycle", int'(seq_done), 0);
      chk("R8 no second run", int'(out_valid), 0);
   endtask

   // R9: out-of-range length starts nothing
   task automatic bad_start(input int vl);
      @(negedge clk);
      vec_len = 7'(vl); sub_code = 2'd1; mode_word = 16'h0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R9 no valid", int'(out_valid), 0);
         chk("R9 no done", int'(seq_done), 0);
         @(negedge clk);
      end
   endtask

   task automatic check_reset();
      chk("R1 valid in reset", int'(out_valid), 0);
      chk("R1 done in reset", int'(seq_done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 valid after reset", int'(out_valid), 0);
      chk("R1 done after reset", int'(seq_done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset();
      run_seq(4, 1, 16'h0000, 0, 0);   // copy, 2 lanes (R3)
      run_seq(5, 2, 16'h4000, 0, 0);   // pack: planar source (R5)
      run_seq(6, 3, 16'h8000, 1, 0);   // unpack with stalls (R5 R7)
      run_seq(3, 2, 16'hC000, 1, 1);   // both planar, stalls, injected start (R6 R8)
      run_seq(7, 3, 16'h3FFF, 0, 0);   // other mode bits ignored (R5)
      run_seq(1, 0, 16'hC000, 0, 0);   // single pair
      run_seq(64, 3, 16'h4000, 1, 0);  // largest run, offsets up to 255 (R2 R4)
      run_seq(9, 0, 16'h8000, 0, 1);   // one lane: planar equals interleaved
      bad_start(0);
      bad_start(65);
      run_seq(2, 1, 16'hC000, 0, 0);   // still works after ignored starts
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule